// File: doc/BRIEF.md
# Multi-Cycle Load/Store Datapath

This block is the data side of a small 32-bit processor that runs each instruction over several short clock cycles. Dedicated holding registers separate the steps: the current instruction word, two operand latches, an ALU result latch and a memory data latch. Because of them, one step's logic only has to settle within one short cycle. The supported work is register-register ALU operations, OR with an immediate, word loads, word stores and a branch on equality.

The datapath takes no decisions of its own. An external sequencer drives every latch enable, operand select, destination select and program-counter update. The datapath returns to that sequencer the opcode and function fields of the latched instruction and an equality flag from the ALU. Instruction memory and data memory sit on two separate ports, and both are read combinationally. The program counter moves only in the last step of each instruction.

Top module: `mcyc_datapath`

## Requirements
- R1: While reset is high at a rising edge, the program counter and all holding registers become zero. So after reset the instruction address, data address and store data read 0, opcode and function read 0, and the data write strobe is low.
- R2: With `ir_load` high at an edge, the instruction register takes `imem_rdata` from the address in `imem_addr`. `opcode` shows instruction bits 31:26 and `funct` shows bits 5:0. Without `ir_load` both outputs hold.
- R3: With `ab_load` high, operand A takes the register named by bits 25:21 and operand B takes the register named by bits 20:16. Without `ab_load` both hold, and B is visible on `dmem_wdata`.
- R4: With `res_load` high, the result latch takes the ALU output and shows it on `dmem_addr`. The `alu_op` codes are 0 add, 1 subtract, 2 AND, 3 OR and 4 signed set-less-than, which yields 1 or 0.
- R5: With `alu_b_imm` and `imm_zext` both high, the second ALU operand is the 16-bit immediate (bits 15:0) padded with zeros, so OR-immediate never sign-fills.
- R6: With `alu_b_imm` high and `imm_zext` low, the second operand is the immediate sign-extended from bit 15. This forms load and store effective addresses, and negative offsets work.
- R7: With `mdr_load` high, the memory data latch takes `dmem_rdata`. A write with `wb_sel_mem` high then puts that latched word into the register file.
- R8: `dmem_we` follows `mem_write` while `dmem_addr` holds the result latch and `dmem_wdata` holds operand B. One store therefore writes B to the computed address in one cycle.
- R9: With `reg_write` high, the register file is written at the edge. The destination is bits 15:11 when `dst_sel_rd` is high and bits 20:16 when it is low. The data is the result latch, or the memory latch when `wb_sel_mem` is high.
- R10: `zero_flag` is high exactly when the ALU output is zero. With `pc_load` high the PC becomes PC+4. With `pc_take_branch` also high it becomes PC+4 plus the sign-extended immediate times 4.
- R11: The PC changes only on an edge with `pc_load` high. Fetch, decode, execute and memory steps without it leave `imem_addr` unchanged.
- R12: Register 0 reads as zero, and writes aimed at it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Program counter, used as instruction address |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data address, from the result latch |
| dmem_wdata | output | 32 | Store data, from operand B |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_rdata | input | 32 | Data word at dmem_addr |
| ir_load | input | 1 | Latch the instruction word |
| ab_load | input | 1 | Latch both register operands |
| alu_op | input | 3 | ALU operation code |
| alu_b_imm | input | 1 | Second ALU operand is the immediate |
| imm_zext | input | 1 | Zero-extend the immediate instead of sign-extending it |
| res_load | input | 1 | Latch the ALU output |
| mdr_load | input | 1 | Latch the data memory read |
| mem_write | input | 1 | Request a data memory write |
| wb_sel_mem | input | 1 | Write-back data comes from the memory latch |
| dst_sel_rd | input | 1 | Write-back destination is bits 15:11 |
| reg_write | input | 1 | Write the register file |
| pc_load | input | 1 | Update the program counter |
| pc_take_branch | input | 1 | PC update uses the branch target |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |
| zero_flag | output | 1 | ALU output equals zero |

## Verification
The bench builds the block with its default 32-entry register file, so every 5-bit register field in the instruction maps to a real register. This lets the bench use register 0 as a discard target and read any register back with an add of that register and zero. Words are 32 bits, so the stimulus can cover sign extension of negative offsets, a negative subtract result, and a branch target behind the current PC.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    localparam int WORD_W = 32;
    localparam int IMM_W  = 16;
    localparam int PC_STEP = 4;
    localparam int BR_SHIFT = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic [5:0] opcode;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] rd;
        logic [4:0] shamt;
        logic [5:0] funct;
    } instr_t;

    function automatic word_t imm_sign(input logic [IMM_W-1:0] v);
        return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic word_t imm_zero(input logic [IMM_W-1:0] v);
        return {{(WORD_W-IMM_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/mcyc_regfile.sv
module mcyc_regfile #(
    parameter int NREGS = 32,
    parameter int W     = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    output logic [W-1:0]  rd1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd2
);

    logic [W-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/mcyc_alu.sv
module mcyc_alu
    import mcyc_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mcyc_pc_unit.sv
module mcyc_pc_unit
    import mcyc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pc_load,
    input  logic             take,
    input  logic [IMM_W-1:0] offset,
    output word_t            pc
);

    word_t pc_q;
    word_t seq_pc;
    word_t br_pc;

    assign seq_pc = pc_q + word_t'(PC_STEP);
    assign br_pc  = seq_pc + (imm_sign(offset) << BR_SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (pc_load) begin
            pc_q <= take ? br_pc : seq_pc;
        end
    end

    assign pc = pc_q;

endmodule

// File: rtl/mcyc_datapath.sv
module mcyc_datapath
    import mcyc_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata,
    input  logic        ir_load,
    input  logic        ab_load,
    input  logic [2:0]  alu_op,
    input  logic        alu_b_imm,
    input  logic        imm_zext,
    input  logic        res_load,
    input  logic        mdr_load,
    input  logic        mem_write,
    input  logic        wb_sel_mem,
    input  logic        dst_sel_rd,
    input  logic        reg_write,
    input  logic        pc_load,
    input  logic        pc_take_branch,
    output logic [5:0]  opcode,
    output logic [5:0]  funct,
    output logic        zero_flag
);

    instr_t ir_q;
    word_t  a_q, b_q, res_q, mdr_q;
    word_t  rf_a, rf_b, alu_b, alu_y, wb_data;
    word_t  imm_ext;
    logic [IMM_W-1:0] imm16;
    logic [AW-1:0]    wb_addr;

    assign imm16   = ir_q[IMM_W-1:0];
    assign imm_ext = imm_zext ? imm_zero(imm16) : imm_sign(imm16);
    assign alu_b   = alu_b_imm ? imm_ext : b_q;
    assign wb_data = wb_sel_mem ? mdr_q : res_q;
    assign wb_addr = dst_sel_rd ? ir_q.rd[AW-1:0] : ir_q.rt[AW-1:0];

    mcyc_regfile #(.NREGS(NREGS), .W(WORD_W)) u_rf (
        .clk   (clk),
        .we    (reg_write),
        .waddr (wb_addr),
        .wdata (wb_data),
        .ra1   (ir_q.rs[AW-1:0]),
        .rd1   (rf_a),
        .ra2   (ir_q.rt[AW-1:0]),
        .rd2   (rf_b)
    );

    mcyc_alu #(.W(WORD_W)) u_alu (
        .a    (a_q),
        .b    (alu_b),
        .op   (alu_op_e'(alu_op)),
        .y    (alu_y),
        .zero (zero_flag)
    );

    mcyc_pc_unit u_pc (
        .clk     (clk),
        .rst     (rst),
        .pc_load (pc_load),
        .take    (pc_take_branch),
        .offset  (imm16),
        .pc      (imem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            res_q <= '0;
            mdr_q <= '0;
        end else begin
            if (ir_load)  ir_q  <= instr_t'(imem_rdata);
            if (ab_load)  a_q   <= rf_a;
            if (ab_load)  b_q   <= rf_b;
            if (res_load) res_q <= alu_y;
            if (mdr_load) mdr_q <= dmem_rdata;
        end
    end

    assign dmem_addr  = res_q;
    assign dmem_wdata = b_q;
    assign dmem_we    = mem_write;
    assign opcode     = ir_q.opcode;
    assign funct      = ir_q.funct;

endmodule

// File: rtl/mcyc_datapath_chk.sv
module mcyc_datapath_chk (
    input logic        clk,
    input logic        rst,
    input logic        ir_load,
    input logic        ab_load,
    input logic        mdr_load,
    input logic        pc_load,
    input logic        pc_take_branch,
    input logic [31:0] imem_addr,
    input logic [31:0] dmem_addr,
    input logic [31:0] dmem_wdata,
    input logic [31:0] dmem_rdata,
    input logic [5:0]  opcode,
    input logic [5:0]  funct,
    input logic [31:0] ir_word,
    input logic [31:0] a_val,
    input logic [31:0] mdr_val
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (imem_addr == 32'd0 && dmem_addr == 32'd0 && dmem_wdata == 32'd0));

    assert_ir_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!rst && !ir_load) |=> ($stable(opcode) && $stable(funct)));

    assert_b_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && !ab_load) |=> $stable(dmem_wdata));

    assert_mdr_capture_R7: assert property (@(posedge clk) disable iff (rst)
        mdr_load |=> (mdr_val == $past(dmem_rdata)));

    assert_pc_seq_R10: assert property (@(posedge clk) disable iff (rst)
        (pc_load && !pc_take_branch) |=> (imem_addr == $past(imem_addr) + 32'd4));

    assert_pc_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!rst && !pc_load) |=> $stable(imem_addr));

    assert_reg0_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (ab_load && ir_word[25:21] == 5'd0) |=> (a_val == 32'd0));

endmodule

bind mcyc_datapath mcyc_datapath_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .ir_load        (ir_load),
    .ab_load        (ab_load),
    .mdr_load       (mdr_load),
    .pc_load        (pc_load),
    .pc_take_branch (pc_take_branch),
    .imem_addr      (imem_addr),
    .dmem_addr      (dmem_addr),
    .dmem_wdata     (dmem_wdata),
    .dmem_rdata     (dmem_rdata),
    .opcode         (opcode),
    .funct          (funct),
    .ir_word        (ir_q),
    .a_val          (a_q),
    .mdr_val        (mdr_q)
);

// File: tb/mcyc_datapath_test.sv
module mcyc_datapath_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;
    logic        ir_load, ab_load, alu_b_imm, imm_zext, res_load, mdr_load;
    logic        mem_write, wb_sel_mem, dst_sel_rd, reg_write, pc_load, pc_take_branch;
    logic [2:0]  alu_op;
    logic [5:0]  opcode, funct;
    logic        zero_flag;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_pc = 32'd0;
    logic [31:0] dmem [16];

    always #5 clk = ~clk;

    assign dmem_rdata = dmem[dmem_addr[5:2]];
    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[5:2]] <= dmem_wdata;
    end

    mcyc_datapath uut (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .dmem_rdata(dmem_rdata),
        .ir_load(ir_load), .ab_load(ab_load), .alu_op(alu_op), .alu_b_imm(alu_b_imm),
        .imm_zext(imm_zext), .res_load(res_load), .mdr_load(mdr_load), .mem_write(mem_write),
        .wb_sel_mem(wb_sel_mem), .dst_sel_rd(dst_sel_rd), .reg_write(reg_write),
        .pc_load(pc_load), .pc_take_branch(pc_take_branch),
        .opcode(opcode), .funct(funct), .zero_flag(zero_flag)
    );

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] b;
        logic [2:0]  op;
        logic [31:0] res;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{16'h1234, 16'h0F0F, 3'd0, 32'h0000_2143},
        '{16'h0005, 16'h0009, 3'd1, 32'hFFFF_FFFC},
        '{16'hF0F0, 16'h3C3C, 3'd2, 32'h0000_3030},
        '{16'hF0F0, 16'h0F0F, 3'd3, 32'h0000_FFFF},
        '{16'h0003, 16'h0007, 3'd4, 32'h0000_0001},
        '{16'h0007, 16'h0003, 3'd4, 32'h0000_0000},
        '{16'h8000, 16'h8000, 3'd1, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_ctl();
        ir_load = 0; ab_load = 0; alu_op = 3'd0; alu_b_imm = 0; imm_zext = 0;
        res_load = 0; mdr_load = 0; mem_write = 0; wb_sel_mem = 0; dst_sel_rd = 0;
        reg_write = 0; pc_load = 0; pc_take_branch = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        clear_ctl();
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic fetch_decode(input logic [31:0] w);
        chk("R10 pc at fetch", imem_addr, exp_pc);
        imem_rdata = w;
        ir_load = 1;
        tick();
        chk("R2 opcode", {26'd0, opcode}, {26'd0, w[31:26]});
        chk("R2 funct", {26'd0, funct}, {26'd0, w[5:0]});
        ab_load = 1;
        tick();
        chk("R11 pc held through decode", imem_addr, exp_pc);
    endtask

    task automatic finish_wb(input logic to_rd, input logic from_mem);
        reg_write = 1; dst_sel_rd = to_rd; wb_sel_mem = from_mem; pc_load = 1;
        tick();
        exp_pc = exp_pc + 32'd4;
    endtask

    task automatic run_ori(input int rt, input int rs, input logic [15:0] imm);
        fetch_decode(enc_i(6'h0D, rs, rt, imm));
        alu_op = 3'd3; alu_b_imm = 1; imm_zext = 1; res_load = 1;
        tick();
        finish_wb(1'b0, 1'b0);
    endtask

    task automatic peek(input int r, output logic [31:0] v);
        fetch_decode(enc_r(r, 0, 0, 6'h20));
        alu_op = 3'd0; res_load = 1;
        tick();
        v = dmem_addr;
        finish_wb(1'b1, 1'b0);
    endtask

    task automatic run_beq(input int rs, input int rt, input logic [15:0] imm,
                           input logic exp_eq, input string req);
        logic [31:0] tgt;
        fetch_decode(enc_i(6'h04, rs, rt, imm));
        alu_op = 3'd1;
        #1;
        chk({req, " equal flag"}, {31'd0, zero_flag}, {31'd0, exp_eq});
        pc_load = 1; pc_take_branch = zero_flag;
        tgt = exp_eq ? exp_pc + 32'd4 + ({{16{imm[15]}}, imm} << 2) : exp_pc + 32'd4;
        tick();
        exp_pc = tgt;
        chk({req, " next pc"}, imem_addr, exp_pc);
    endtask

    logic [31:0] v;
    bit done = 0;

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        clear_ctl();
        imem_rdata = 32'd0;
        for (int i = 0; i < 16; i++) dmem[i] = 32'd0;
        dmem[14] = 32'hCAFE_F00D;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;

        // R1: reset state
        chk("R1 pc", imem_addr, 32'd0);
        chk("R1 result latch", dmem_addr, 32'd0);
        chk("R1 operand B", dmem_wdata, 32'd0);
        chk("R1 opcode/funct", {20'd0, opcode, funct}, 32'd0);
        chk("R1 write strobe", {31'd0, dmem_we}, 32'd0);

        // R4 and R9: table of ALU operations via rd write-back
        for (int k = 0; k < 7; k++) begin
            run_ori(1, 0, VECS[k].a);
            run_ori(2, 0, VECS[k].b);
            fetch_decode(enc_r(1, 2, 3, {3'b100, VECS[k].op}));
            chk("R3 operand B from rt", dmem_wdata, {16'd0, VECS[k].b});
            alu_op = VECS[k].op; res_load = 1;
            tick();
            chk("R4 alu result", dmem_addr, VECS[k].res);
            finish_wb(1'b1, 1'b0);
            peek(3, v);
            chk("R9 rd destination", v, VECS[k].res);
        end

        // R5: zero-extended immediate with bit 15 set
        run_ori(4, 0, 16'h8001);
        peek(4, v);
        chk("R5 zero extension", v, 32'h0000_8001);

        // R6 and R7: load with negative offset
        run_ori(5, 0, 16'h0040);
        fetch_decode(enc_i(6'h23, 5, 6, 16'hFFF8));
        alu_op = 3'd0; alu_b_imm = 1; res_load = 1;
        tick();
        chk("R6 negative offset address", dmem_addr, 32'h0000_0038);
        chk("R11 pc held after execute", imem_addr, exp_pc);
        mdr_load = 1;
        tick();
        chk("R11 pc held after memory read", imem_addr, exp_pc);
        finish_wb(1'b0, 1'b1);
        peek(6, v);
        chk("R7 loaded word in rt", v, 32'hCAFE_F00D);

        // R8: store, PC advanced in memory step
        fetch_decode(enc_i(6'h2B, 5, 6, 16'h0004));
        alu_op = 3'd0; alu_b_imm = 1; res_load = 1;
        tick();
        chk("R6 positive offset address", dmem_addr, 32'h0000_0044);
        mem_write = 1; pc_load = 1;
        #1;
        chk("R8 write strobe", {31'd0, dmem_we}, 32'd1);
        chk("R8 store data", dmem_wdata, 32'hCAFE_F00D);
        tick();
        exp_pc = exp_pc + 32'd4;
        chk("R8 memory written", dmem[1], 32'hCAFE_F00D);
        chk("R8 strobe released", {31'd0, dmem_we}, 32'd0);

        // R10: branches
        run_beq(4, 4, 16'h0003, 1'b1, "R10 taken forward");
        run_beq(4, 6, 16'h0003, 1'b0, "R10 not taken");
        run_beq(6, 6, 16'hFFFE, 1'b1, "R10 taken backward");

        // R12: register 0 ignores writes
        run_ori(0, 0, 16'h0055);
        peek(0, v);
        chk("R12 register 0 reads zero", v, 32'd0);

        // R1: reset mid-run
        rst = 1;
        tick();
        rst = 0;
        exp_pc = 32'd0;
        chk("R1 pc after reset", imem_addr, 32'd0);
        chk("R1 result latch after reset", dmem_addr, 32'd0);
        chk("R1 opcode after reset", {26'd0, opcode}, 32'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule